// File: doc/BRIEF.md
# Periodic Checkpoint and Rollback Controller

This block keeps a recoverable copy of a processor core's architectural state. At a programmable interval it stalls the core and copies every state word (program counter, register file, small data memory) into one of two save slots in a protected memory, using a simple request/acknowledge port. When a user-logic error detector reports a fault, the controller stalls the core again and copies the most recent complete checkpoint back into the core, which then resumes from that point.

A second error source, the configuration scrubber, is handled on its own path. A configuration error raises a repair request that stays up until the scrubber reports completion. A configuration error alone causes no rollback. If a rollback is needed while a repair is still pending, the controller holds the core until the repair is done and only then starts the restore. When there is no complete checkpoint to return to, the controller raises a sticky fatal flag.

Top module: `ckpt_rollback_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `core_stall`, `mem_req`, `fatal_err`, `repair_req` and `st_we` are all low.
- R2: With no error activity, the core runs unstalled for exactly `period`+1 cycles between the end of one checkpoint sequence and the start of the next. A period of 0 gives one unstalled cycle, so checkpointing is continuous.
- R3: A checkpoint stalls the core and writes state words in ascending index order (index 0 = program counter, 1..NREGS = registers, the rest = data memory). Each write goes to `mem_addr` = {slot, index} with `mem_wdata` equal to the core word at `st_addr` = index. The controller moves to the next word only on `mem_ack`.
- R4: The first checkpoint after reset uses slot 0. Every later checkpoint targets the slot opposite to the last complete one. A checkpoint counts as complete only once its final word has been acknowledged.
- R5: After `ul_err`, the controller reads every word of the last complete slot in index order. On each read acknowledge it drives `st_we` with `st_addr` = index and `st_wdata` = `mem_rdata`. While a read is waiting for its acknowledge, the address is held. The stall drops after the last word, and the core holds exactly the checkpointed contents.
- R6: A `ul_err` during a checkpoint abandons that checkpoint. The restore then comes from the previous complete slot, and the abandoned slot is not treated as complete.
- R7: `cfg_err` raises `repair_req` in the next cycle. `repair_req` stays high until `repair_done`. A configuration error alone triggers no restore.
- R8: If a rollback is needed while `repair_req` is high, the core stays stalled and no memory read is issued until the repair is done. The restore follows after that.
- R9: A `ul_err` with no complete checkpoint sets `fatal_err`. `fatal_err` stays set until reset, with the core stalled and no memory access.
- R10: The save memory is accessed only while the core is stalled, and `st_we` occurs only on an acknowledged restore read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | PERIOD_W | Unstalled cycles between checkpoints, minus one |
| ul_err | input | 1 | User-logic error detected (pulse) |
| cfg_err | input | 1 | Configuration memory error detected (pulse) |
| repair_done | input | 1 | Scrubber finished the repair |
| repair_req | output | 1 | Configuration repair requested |
| core_stall | output | 1 | Hold the core |
| fatal_err | output | 1 | Error with no checkpoint to return to |
| st_addr | output | IDX_W | Core state word index |
| st_rdata | input | DATA_W | Core state word read data |
| st_we | output | 1 | Core state word write enable |
| st_wdata | output | DATA_W | Core state word write data |
| mem_req | output | 1 | Save memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | IDX_W+1 | {slot, word index} |
| mem_wdata | output | DATA_W | Save memory write data |
| mem_ack | input | 1 | Request accepted (read data valid) |
| mem_rdata | input | DATA_W | Save memory read data |

## Verification
The bench uses 8 registers and 8 data-memory words. This gives 17 state words, so the 5-bit index does not fill its range, and the index bound and the slot bit in the address are both exercised. Periods of 0, 5, 12 and 40 cover the continuous case, short intervals and long intervals. The memory model's acknowledge gap is set to 0, 1, 2 and 3 cycles. The long gaps stretch a checkpoint over tens of cycles, which leaves room to inject an error part-way through a save, and to hold a rollback behind a pending repair.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_SAVE,
        CS_WAIT,
        CS_RESTORE,
        CS_FATAL
    } ckpt_state_e;

    typedef struct packed {
        logic ul_pend;
        logic repair_pend;
    } err_flags_t;

    // Where a rollback request leads, given pending repair and checkpoint state
    function automatic ckpt_state_e recover_target(input err_flags_t f, input logic have_ckpt);
        if (f.repair_pend)
            return CS_WAIT;
        else if (have_ckpt)
            return CS_RESTORE;
        else
            return CS_FATAL;
    endfunction

endpackage

// File: rtl/ckpt_err_track.sv
module ckpt_err_track
    import ckpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ul_err,
    input  logic       cfg_err,
    input  logic       repair_done,
    input  logic       ul_take,
    output err_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            if (ul_err)
                flags.ul_pend <= 1'b1;
            else if (ul_take)
                flags.ul_pend <= 1'b0;
            if (cfg_err)
                flags.repair_pend <= 1'b1;
            else if (repair_done)
                flags.repair_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ckpt_period_timer.sv
module ckpt_period_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    logic [PERIOD_W-1:0] cnt_q;

    assign expire = run && (cnt_q >= period);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + PERIOD_W'(1);
    end
endmodule

// File: rtl/ckpt_slot_book.sv
module ckpt_slot_book (
    input  logic clk,
    input  logic rst,
    input  logic begin_save,
    input  logic commit,
    output logic tgt_slot,
    output logic cur_slot,
    output logic have_ckpt
);
    localparam int NSLOTS = 2;

    logic [NSLOTS-1:0] valid_q;
    logic              latest_q;

    assign cur_slot  = latest_q;
    assign tgt_slot  = ~latest_q;
    assign have_ckpt = valid_q[latest_q];

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                valid_q[s] <= 1'b0;
            else if (commit && (tgt_slot == 1'(s)))
                valid_q[s] <= 1'b1;
            else if (begin_save && (tgt_slot == 1'(s)))
                valid_q[s] <= 1'b0;
        end
    end

    // reset value makes slot 0 the first target
    always_ff @(posedge clk) begin
        if (rst)
            latest_q <= 1'b1;
        else if (commit)
            latest_q <= tgt_slot;
    end
endmodule

// File: rtl/ckpt_rollback_ctrl.sv
module ckpt_rollback_ctrl
    import ckpt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NREGS      = 8,
    parameter int DMEM_WORDS = 8,
    parameter int PERIOD_W   = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [PERIOD_W-1:0]                       period,
    input  logic                                      ul_err,
    input  logic                                      cfg_err,
    input  logic                                      repair_done,
    output logic                                      repair_req,
    output logic                                      core_stall,
    output logic                                      fatal_err,
    output logic [$clog2(1+NREGS+DMEM_WORDS)-1:0]     st_addr,
    input  logic [DATA_W-1:0]                         st_rdata,
    output logic                                      st_we,
    output logic [DATA_W-1:0]                         st_wdata,
    output logic                                      mem_req,
    output logic                                      mem_we,
    output logic [$clog2(1+NREGS+DMEM_WORDS):0]       mem_addr,
    output logic [DATA_W-1:0]                         mem_wdata,
    input  logic                                      mem_ack,
    input  logic [DATA_W-1:0]                         mem_rdata
);
    localparam int N_WORDS = 1 + NREGS + DMEM_WORDS;
    localparam int IDX_W   = $clog2(N_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    ckpt_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    err_flags_t      flags;
    logic            ul_take, begin_save, commit;
    logic            expire, tgt_slot, cur_slot, have_ckpt;

    ckpt_err_track u_err (
        .clk         (clk),
        .rst         (rst),
        .ul_err      (ul_err),
        .cfg_err     (cfg_err),
        .repair_done (repair_done),
        .ul_take     (ul_take),
        .flags       (flags)
    );

    ckpt_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == CS_IDLE),
        .period (period),
        .expire (expire)
    );

    ckpt_slot_book u_slots (
        .clk        (clk),
        .rst        (rst),
        .begin_save (begin_save),
        .commit     (commit),
        .tgt_slot   (tgt_slot),
        .cur_slot   (cur_slot),
        .have_ckpt  (have_ckpt)
    );

    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        ul_take    = 1'b0;
        begin_save = 1'b0;
        commit     = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
                if (flags.ul_pend) begin
                    ul_take = 1'b1;
                    state_d = recover_target(flags, have_ckpt);
                    idx_d   = '0;
                end else if (expire) begin
                    begin_save = 1'b1;
                    state_d    = CS_SAVE;
                    idx_d      = '0;
                end
            end
            CS_SAVE: begin
                if (flags.ul_pend) begin
                    // abandon the partial checkpoint
                    ul_take = 1'b1;
                    state_d = recover_target(flags, have_ckpt);
                    idx_d   = '0;
                end else if (mem_ack) begin
                    if (idx_q == LAST_IDX) begin
                        commit  = 1'b1;
                        state_d = CS_IDLE;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            CS_WAIT: begin
                if (!flags.repair_pend) begin
                    state_d = have_ckpt ? CS_RESTORE : CS_FATAL;
                    idx_d   = '0;
                end
            end
            CS_RESTORE: begin
                if (mem_ack) begin
                    if (idx_q == LAST_IDX)
                        state_d = CS_IDLE;
                    else
                        idx_d = idx_q + IDX_W'(1);
                end
            end
            CS_FATAL: ;
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign core_stall = (state_q != CS_IDLE);
    assign fatal_err  = (state_q == CS_FATAL);
    assign repair_req = flags.repair_pend;
    assign mem_req    = (state_q == CS_SAVE) || (state_q == CS_RESTORE);
    assign mem_we     = (state_q == CS_SAVE);
    assign mem_addr   = {(state_q == CS_SAVE) ? tgt_slot : cur_slot, idx_q};
    assign mem_wdata  = st_rdata;
    assign st_addr    = idx_q;
    assign st_we      = (state_q == CS_RESTORE) && mem_ack;
    assign st_wdata   = mem_rdata;
endmodule

// File: rtl/ckpt_rollback_ctrl_chk.sv
module ckpt_rollback_ctrl_chk #(
    parameter int NREGS      = 8,
    parameter int DMEM_WORDS = 8
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  cfg_err,
    input logic                                  repair_done,
    input logic                                  repair_req,
    input logic                                  core_stall,
    input logic                                  fatal_err,
    input logic                                  st_we,
    input logic                                  mem_req,
    input logic                                  mem_we,
    input logic [$clog2(1+NREGS+DMEM_WORDS):0]   mem_addr,
    input logic                                  mem_ack
);
    localparam int N_WORDS = 1 + NREGS + DMEM_WORDS;
    localparam int IDX_W   = $clog2(N_WORDS);

    p_mem_only_stalled_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> core_stall);

    p_st_we_on_read_ack_r10: assert property (@(posedge clk) disable iff (rst)
        st_we |-> (mem_req && mem_ack && !mem_we));

    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ({1'b0, mem_addr[IDX_W-1:0]} < (IDX_W+1)'(N_WORDS)));

    p_read_addr_held_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_repair_raised_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> repair_req);

    p_repair_held_r7: assert property (@(posedge clk) disable iff (rst)
        (repair_req && !repair_done) |=> repair_req);

    p_restore_after_repair_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req && !mem_we) |-> !$past(repair_req));

    p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        fatal_err |=> fatal_err);

    p_fatal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        fatal_err |-> (core_stall && !mem_req));
endmodule

bind ckpt_rollback_ctrl ckpt_rollback_ctrl_chk #(
    .NREGS      (NREGS),
    .DMEM_WORDS (DMEM_WORDS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_err     (cfg_err),
    .repair_done (repair_done),
    .repair_req  (repair_req),
    .core_stall  (core_stall),
    .fatal_err   (fatal_err),
    .st_we       (st_we),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/ckpt_rollback_ctrl_tb_top.sv
module ckpt_rollback_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int NREGS      = 8;
    localparam int DMEM_WORDS = 8;
    localparam int PERIOD_W   = 16;
    localparam int N_WORDS    = 1 + NREGS + DMEM_WORDS;
    localparam int IDX_W      = $clog2(N_WORDS);
    localparam int AW         = IDX_W + 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [PERIOD_W-1:0] period = '0;
    logic                ul_err = 1'b0, cfg_err = 1'b0, repair_done = 1'b0;
    logic                repair_req, core_stall, fatal_err;
    logic [IDX_W-1:0]    st_addr;
    logic [DATA_W-1:0]   st_rdata, st_wdata, mem_wdata, mem_rdata;
    logic                st_we, mem_req, mem_we;
    logic                mem_ack = 1'b0;
    logic [AW-1:0]       mem_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckpt_rollback_ctrl #(
        .DATA_W(DATA_W), .NREGS(NREGS), .DMEM_WORDS(DMEM_WORDS), .PERIOD_W(PERIOD_W)
    ) dut_i (
        .clk(clk), .rst(rst), .period(period), .ul_err(ul_err), .cfg_err(cfg_err),
        .repair_done(repair_done), .repair_req(repair_req), .core_stall(core_stall),
        .fatal_err(fatal_err), .st_addr(st_addr), .st_rdata(st_rdata), .st_we(st_we),
        .st_wdata(st_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // ---------------- core and save memory models ----------------
    logic [DATA_W-1:0] core [N_WORDS];
    logic [DATA_W-1:0] snap [N_WORDS];
    logic [DATA_W-1:0] smem [2**AW];

    assign st_rdata  = core[st_addr];
    assign mem_rdata = smem[mem_addr];

    function automatic int pick_word(input logic [DATA_W-1:0] pc);
        return 1 + int'(pc[9:2]) % (N_WORDS - 1);
    endfunction

    initial begin
        for (int i = 0; i < N_WORDS; i++) core[i] = DATA_W'(32'hA500_0000 + i * 32'h111);
        for (int i = 0; i < 2**AW; i++) smem[i] = '0;
    end

    always @(posedge clk) begin
        if (st_we)
            core[st_addr] <= st_wdata;
        else if (!rst && !core_stall) begin
            core[0] <= core[0] + 32'd4;
            core[pick_word(core[0])] <= core[pick_word(core[0])] ^ (core[0] * 32'h9E37);
        end
        if (mem_req && mem_ack && mem_we)
            smem[mem_addr] <= mem_wdata;
    end

    int ack_gap = 0;
    int wcnt = 0;
    always @(negedge clk) begin
        if (mem_req && wcnt >= ack_gap) begin
            mem_ack = 1'b1;
            wcnt = 0;
        end else begin
            mem_ack = 1'b0;
            if (mem_req) wcnt++;
        end
    end

    // ---------------- scoreboard ----------------
    int errors = 0, checks = 0;
    logic [IDX_W+DATA_W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int  run_cnt = 0, last_run = 0, n_runs = 0, n_snaps = 0, n_restores = 0, save_pos = 0;
    bit  have_snap = 0;
    logic last_slot = 1'b0;
    logic [IDX_W-1:0] widx;
    logic [IDX_W+DATA_W-1:0] expd;

    always @(negedge clk) begin
        #1;
        if (rst) begin
            run_cnt = 0;
            save_pos = 0;
        end else begin
            if (!core_stall) run_cnt++;
            else if (run_cnt != 0) begin
                last_run = run_cnt; n_runs++; run_cnt = 0;
            end
            if (mem_req && mem_ack)
                chk(core_stall, "R10", "memory access without stall", 0, 1);
            if (mem_req && mem_ack && mem_we) begin
                widx = mem_addr[IDX_W-1:0];
                chk(32'(widx) == 32'(save_pos), "R3", "save word order", 64'(widx), 64'(save_pos));
                chk(mem_wdata == core[widx], "R3", "save word data", 64'(mem_wdata), 64'(core[widx]));
                if (32'(widx) == N_WORDS - 1) begin
                    if (have_snap)
                        chk(mem_addr[IDX_W] != last_slot, "R4", "slot alternation",
                            64'(mem_addr[IDX_W]), 64'(!last_slot));
                    else
                        chk(mem_addr[IDX_W] == 1'b0, "R4", "first slot", 64'(mem_addr[IDX_W]), 0);
                    last_slot = mem_addr[IDX_W];
                    have_snap = 1;
                    for (int i = 0; i < N_WORDS; i++) snap[i] = core[i];
                    n_snaps++;
                    save_pos = 0;
                end else save_pos++;
            end
            if (mem_req && !mem_we) begin
                save_pos = 0;
                if (mem_ack)
                    chk(mem_addr[IDX_W] == last_slot, "R5", "restore slot",
                        64'(mem_addr[IDX_W]), 64'(last_slot));
            end
            if (st_we) begin
                n_restores++;
                if (exp_q.size() == 0)
                    chk(0, "R5", "unexpected restore write", 64'(st_addr), 0);
                else begin
                    expd = exp_q.pop_front();
                    chk({st_addr, st_wdata} == expd, "R5", "restore word",
                        64'({st_addr, st_wdata}), 64'(expd));
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic tick(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        have_snap = 0;
        exp_q.delete();
        rst = 1'b0;
    endtask

    task automatic push_expected();
        for (int i = 0; i < N_WORDS; i++)
            exp_q.push_back({IDX_W'(i), snap[i]});
    endtask

    task automatic wait_snaps(input int target, input string req);
        int n = 0;
        while (n_snaps < target && n < 20000) begin tick(); n++; end
        if (n_snaps < target) chk(0, req, "timeout waiting for checkpoint", 64'(n_snaps), 64'(target));
    endtask

    task automatic wait_runs(input int target, input string req);
        int n = 0;
        while (n_runs < target && n < 20000) begin tick(); n++; end
        if (n_runs < target) chk(0, req, "timeout waiting for run", 64'(n_runs), 64'(target));
    endtask

    task automatic wait_stall(input logic lvl, input string req);
        int n = 0;
        while (core_stall !== lvl && n < 20000) begin tick(); n++; end
        if (core_stall !== lvl) chk(0, req, "timeout waiting for stall level", 64'(core_stall), 64'(lvl));
    endtask

    task automatic check_core_is_snap(input string req);
        bit same = 1;
        for (int i = 0; i < N_WORDS; i++) if (core[i] !== snap[i]) same = 0;
        chk(same, req, "core state equals checkpoint", 64'(core[0]), 64'(snap[0]));
    endtask

    task automatic pulse_ul();
        push_expected();
        ul_err = 1'b1;
        tick();
        ul_err = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    int base, rcount;
    bit bad;

    initial begin
        // R1: reset state
        period = 16'd1000;
        rst = 1'b1;
        tick(2);
        chk(!core_stall && !mem_req && !fatal_err && !repair_req && !st_we, "R1",
            "outputs during reset", {core_stall, mem_req, fatal_err, repair_req, st_we}, 0);
        rst = 1'b0;
        tick();
        chk(!core_stall && !mem_req && !fatal_err && !repair_req && !st_we, "R1",
            "outputs after reset", {core_stall, mem_req, fatal_err, repair_req, st_we}, 0);

        // R9: error before any checkpoint
        ul_err = 1'b1; tick(); ul_err = 1'b0;
        tick(2);
        chk(fatal_err == 1'b1, "R9", "fatal raised", 64'(fatal_err), 1);
        chk(core_stall == 1'b1 && mem_req == 1'b0, "R9", "stalled and quiet", {core_stall, mem_req}, 2'b10);
        tick(20);
        chk(fatal_err == 1'b1 && n_restores == 0, "R9", "fatal sticky, no restore",
            {fatal_err, 32'(n_restores)}, 64'h1_0000_0000);

        // R2: checkpoint interval
        period = 16'd5; ack_gap = 0;
        do_reset();
        wait_runs(n_runs + 2, "R2");
        chk(last_run == 6, "R2", "run length period 5", 64'(last_run), 6);
        period = 16'd12; ack_gap = 2;
        wait_runs(n_runs + 2, "R2");
        chk(last_run == 13, "R2", "run length period 12", 64'(last_run), 13);
        period = 16'd0; ack_gap = 0;
        wait_runs(n_runs + 2, "R2");
        chk(last_run == 1, "R2", "run length period 0", 64'(last_run), 1);

        // R5: rollback to latest checkpoint
        period = 16'd40; ack_gap = 1;
        wait_snaps(n_snaps + 2, "R5");
        tick(3);
        pulse_ul();
        wait_stall(1'b1, "R5");
        wait_stall(1'b0, "R5");
        chk(exp_q.size() == 0, "R5", "all restore words seen", 64'(exp_q.size()), 0);
        check_core_is_snap("R5");

        // R6: error in the middle of a checkpoint
        period = 16'd0; ack_gap = 3;
        wait_snaps(n_snaps + 1, "R6");
        base = n_snaps;
        begin
            int n = 0;
            while (save_pos < 4 && n < 2000) begin tick(); n++; end
        end
        pulse_ul();
        wait_stall(1'b0, "R6");
        chk(n_snaps == base, "R6", "aborted checkpoint not completed", 64'(n_snaps), 64'(base));
        chk(exp_q.size() == 0, "R6", "restored previous checkpoint", 64'(exp_q.size()), 0);
        check_core_is_snap("R6");
        wait_snaps(n_snaps + 1, "R6");

        // R7: configuration error alone
        period = 16'd30; ack_gap = 0;
        wait_snaps(n_snaps + 1, "R7");
        rcount = n_restores;
        cfg_err = 1'b1; tick(); cfg_err = 1'b0;
        chk(repair_req == 1'b1, "R7", "repair requested next cycle", 64'(repair_req), 1);
        tick(10);
        chk(repair_req == 1'b1, "R7", "repair held", 64'(repair_req), 1);
        chk(n_restores == rcount && !fatal_err, "R7", "no rollback from config error",
            64'(n_restores), 64'(rcount));
        repair_done = 1'b1; tick(); repair_done = 1'b0;
        chk(repair_req == 1'b0, "R7", "repair cleared", 64'(repair_req), 0);

        // R8: coincident errors wait for repair
        period = 16'd40;
        wait_snaps(n_snaps + 1, "R8");
        tick(2);
        push_expected();
        cfg_err = 1'b1; ul_err = 1'b1;
        tick();
        cfg_err = 1'b0; ul_err = 1'b0;
        tick();
        chk(core_stall == 1'b1, "R8", "stalled while repair pending", 64'(core_stall), 1);
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            if (mem_req || st_we || !core_stall) bad = 1;
            tick();
        end
        chk(!bad, "R8", "no restore before repair done", 64'(bad), 0);
        repair_done = 1'b1; tick(); repair_done = 1'b0;
        wait_stall(1'b0, "R8");
        chk(exp_q.size() == 0, "R8", "restore after repair", 64'(exp_q.size()), 0);
        check_core_is_snap("R8");

        tick(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule